// File: doc/BRIEF.md
# Port input change detector

This block watches an input port of configurable width (eight pins by default) and raises a sticky change flag when the port no longer matches a stored reference. The raw pins pass through a flop synchronizer. The synchronized value is what the core sees when it reads the port. Every read by the core copies that value into the reference. Software must therefore read the port before it enables the detector, or the first comparison is made against a stale reference.

The flag is the detector's bit in the interrupt status register. It sets whenever the detector's mask bit is enabled, whatever the state of the global interrupt enable. The global enable only gates the interrupt request that leaves the block. While the core sleeps, a difference from the reference raises a wake request. This happens only if the detector was enabled in the last cycle before sleep began. Changing the mask bit during sleep does not alter that decision.

Top module: `pin_change_watch`

## Requirements
- R1: During and straight after reset, `flag`, `irq_req` and `wake` are 0, and `port_data` and the reference are all zeros.
- R2: A new value on `pins_async` appears on `port_data` exactly two rising clock edges after it is applied.
- R3: With `chg_en` high, any pattern of one or more pins that differs from the reference sets `flag` on the rising edge after `port_data` first differs, which is three edges after the pin change. A matching pattern leaves `flag` clear.
- R4: While `chg_en` is low, no difference sets `flag`. If a difference is still present when `chg_en` goes high, `flag` sets on the next edge.
- R5: A cycle with `port_rd` high loads `port_data` into the reference. After such a read, an unchanged port leaves `flag` clear, and no set of `flag` is caused in the read cycle itself.
- R6: `flag` stays set until a `flag_clr` cycle. A pin that toggles away and back before the next read still leaves `flag` set. If a difference is still present, `flag_clr` does not clear the flag, because a set wins over a clear.
- R7: `flag` sets regardless of `glob_en`. `irq_req` is high exactly when `flag` and `glob_en` are both high.
- R8: While `sleeping` is high, a difference from the reference drives `wake` high one edge after it reaches `port_data`. This applies only if `chg_en` was high in the last cycle before `sleeping` rose. Raising `chg_en` during sleep does not arm the wake.
- R9: `wake` is 0 in any cycle that follows an edge at which `sleeping` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_async | input | WIDTH | Raw port pins |
| port_rd | input | 1 | Core read of the port; loads the reference |
| chg_en | input | 1 | Mask bit of the detector |
| flag_clr | input | 1 | Software clear of the change flag |
| glob_en | input | 1 | Global interrupt enable |
| sleeping | input | 1 | Core is in sleep mode |
| port_data | output | WIDTH | Synchronized port value returned on a read |
| flag | output | 1 | Sticky change flag |
| irq_req | output | 1 | Interrupt request, flag gated by the global enable |
| wake | output | 1 | Wake request while sleeping |

## Verification
The bench sweeps all 256 difference patterns against shifting reference values. A design that compared only some pins, or compared edges instead of the reference, would miss patterns or would set the flag too early or too late. It makes a pin pulse away and back before any read. A design that tracked the live pins instead of holding the flag would drop the flag. It clears while a difference persists, and it checks that raising the mask bit late still catches an old difference. For sleep, it enables the detector before sleep and again only during sleep. A design that sampled the mask bit live would wake in the wrong case.

// File: rtl/pin_change_watch.sv
module pin_change_watch #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_async,
  input  logic             port_rd,
  input  logic             chg_en,
  input  logic             flag_clr,
  input  logic             glob_en,
  input  logic             sleeping,
  output logic [WIDTH-1:0] port_data,
  output logic             flag,
  output logic             irq_req,
  output logic             wake
);

  logic [SYNC_STAGES-1:0][WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] ref_q;
  logic             armed_q;
  logic             differs;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pins_async};

  assign port_data = sync_q[SYNC_STAGES-1];
  assign differs   = |(port_data ^ ref_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ref_q <= '0;
    else if (port_rd) ref_q <= port_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           flag <= 1'b0;
    else if (chg_en && differs && !port_rd) flag <= 1'b1;
    else if (flag_clr)                    flag <= 1'b0;

  // the mask bit is frozen at sleep entry
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         armed_q <= 1'b0;
    else if (!sleeping) armed_q <= chg_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wake <= 1'b0;
    else        wake <= sleeping && armed_q && differs;

  assign irq_req = flag && glob_en;

endmodule

module pin_change_watch_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] pins_async,
  input logic             port_rd,
  input logic             chg_en,
  input logic             flag_clr,
  input logic             sleeping,
  input logic [WIDTH-1:0] port_data,
  input logic             flag,
  input logic             wake
);

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;

  assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (port_data == $past(pins_async, 2)));

  assert_no_set_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_en && !flag) |=> !flag);

  assert_read_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd && !flag) |=> !flag);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  assert_awake_no_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sleeping |=> !wake);

endmodule

bind pin_change_watch pin_change_watch_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pins_async(pins_async), .port_rd(port_rd),
  .chg_en(chg_en), .flag_clr(flag_clr), .sleeping(sleeping),
  .port_data(port_data), .flag(flag), .wake(wake)
);

// File: tb/pin_change_watch_tb.sv
module pin_change_watch_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins_async = '0;
  logic       port_rd = 1'b0, chg_en = 1'b0, flag_clr = 1'b0;
  logic       glob_en = 1'b0, sleeping = 1'b0;
  logic [7:0] port_data;
  logic       flag, irq_req, wake;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pin_change_watch u_dut (
    .clk(clk), .rst_n(rst_n), .pins_async(pins_async), .port_rd(port_rd),
    .chg_en(chg_en), .flag_clr(flag_clr), .glob_en(glob_en), .sleeping(sleeping),
    .port_data(port_data), .flag(flag), .irq_req(irq_req), .wake(wake)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_read();
    port_rd = 1'b1; tick(); port_rd = 1'b0;
  endtask

  task automatic do_clear();
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
  endtask

  task automatic settle(input logic [7:0] v);
    pins_async = v; tick(3); do_read(); do_clear();
  endtask

  initial begin
    #1;
    check("R1 flag", {7'd0, flag}, 8'd0);
    check("R1 wake", {7'd0, wake}, 8'd0);
    check("R1 port_data", port_data, 8'd0);
    tick(2);
    rst_n = 1'b1;
    tick();
    check("R1 after reset flag", {7'd0, flag}, 8'd0);
    check("R1 after reset irq", {7'd0, irq_req}, 8'd0);

    // R3 sweep over every difference pattern, R2 latency, R7 with glob_en low
    chg_en = 1'b1;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] base;
      base = 8'((v * 73 + 11) & 255);
      settle(base);
      check("R5 no flag after read", {7'd0, flag}, 8'd0);
      pins_async = base ^ 8'(v);
      tick(2);
      check("R2 port_data", port_data, base ^ 8'(v));
      check("R3 not yet", {7'd0, flag}, 8'd0);
      tick();
      check("R3 flag", {7'd0, flag}, {7'd0, v != 0});
      check("R7 irq gated", {7'd0, irq_req}, 8'd0);
    end

    // R7 global enable gates request only
    settle(8'h5A);
    pins_async = 8'h5B; tick(3);
    check("R7 flag without glob_en", {7'd0, flag}, 8'd1);
    glob_en = 1'b1; #1;
    check("R7 irq", {7'd0, irq_req}, 8'd1);
    do_read(); do_clear();
    check("R7 irq drops with flag", {7'd0, irq_req}, 8'd0);
    glob_en = 1'b0;

    // R6 pulse away and back
    settle(8'h3C);
    pins_async = 8'h3D; tick(); pins_async = 8'h3C;
    tick(6);
    check("R6 pulse kept", {7'd0, flag}, 8'd1);
    do_clear();
    check("R6 clear", {7'd0, flag}, 8'd0);
    // R6 clear loses to a persisting difference
    pins_async = 8'h80; tick(4);
    do_clear();
    check("R6 set wins", {7'd0, flag}, 8'd1);
    do_read(); do_clear();
    check("R6 clear after read", {7'd0, flag}, 8'd0);

    // R4 masked detector, then late enable
    chg_en = 1'b0;
    settle(8'h11);
    pins_async = 8'h22; tick(6);
    check("R4 masked", {7'd0, flag}, 8'd0);
    chg_en = 1'b1; tick();
    check("R4 late enable", {7'd0, flag}, 8'd1);
    check("R9 awake", {7'd0, wake}, 8'd0);

    // R8 armed before sleep, mask dropped in sleep
    settle(8'h44);
    sleeping = 1'b1; tick(); chg_en = 1'b0;
    pins_async = 8'h40; tick(2);
    check("R8 not yet", {7'd0, wake}, 8'd0);
    tick();
    check("R8 wake", {7'd0, wake}, 8'd1);
    sleeping = 1'b0; tick();
    check("R9 wake drops", {7'd0, wake}, 8'd0);

    // R8 not armed at entry, enabled in sleep
    settle(8'h40);
    sleeping = 1'b1; tick(); chg_en = 1'b1;
    pins_async = 8'h41; tick(5);
    check("R8 unarmed", {7'd0, wake}, 8'd0);
    sleeping = 1'b0; tick();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule